// File: doc/BRIEF.md
# Group Blink Gate Generator with Multi-Device Phase Sync

This block makes a slow on/off gate that switches a set of LED channels on and off together. A free-running counter divides each blink period into 256 equal slots. Each slot lasts (BLF+1) timebase ticks, so when the tick runs at 6144 Hz the blink rate is 24/(BLF+1) Hz. The gate is open during the first BLD slots of every period. A channel whose blink-enable bit is clear is always released, so its PWM passes straight through. A channel whose enable bit is set is released only while the gate is open, and the channel logic ANDs that release with its PWM.

The period and on-ratio come in through staging inputs. They take effect only when an update pulse commits them, so firmware can change both at once without a visible glitch. A 2-bit mode selects what the shared sync pin does:
- Modes 00 and 01: the pin is driven low.
- Mode 10 (master): the pin drives a square wave at the blink rate. It rises at the start of each period.
- Mode 11 (slave): the pin is an input. A synchronised rising edge on it restarts this device's blink period.

Several devices on one sync wire therefore blink in phase.

Top module: `blink_gen`

## Requirements
- R1: The blink period is 256*(BLF+1) timebase ticks, where BLF is the committed 8-bit period value.
- R2: The blink gate is high in exactly BLD of the 256 slots of each period, counted from the start of the period. With BLD = 0 it never goes high.
- R3: Values on blf_next and bld_next have no effect until a one-cycle update pulse. The update copies both of them at the same time.
- R4: For each channel i, ch_gate[i] is 1 when blink_en[i] is 0, and equals blink_gate when blink_en[i] is 1.
- R5: With sync_mode 00 or 01, sync_oe is 1 and sync_out is 0.
- R6: With sync_mode 10, sync_oe is 1. sync_out is high for the first 128 slots of each period and low for the last 128, giving a square wave at the blink rate.
- R7: With sync_mode 11, sync_oe is 0. sync_in passes through a two-flop synchroniser. A rising edge on it restarts the period at slot 0 on the second clock edge after the edge on which sync_in is first sampled high.
- R8: The slot counter moves only on cycles where tick is 1.
- R9: After reset, the slot counter, the tick prescaler and both committed values are 0. As a result, the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| blf_next | input | 8 | Staged period value BLF |
| bld_next | input | 8 | Staged on-ratio value BLD |
| update | input | 1 | Commit pulse for both staged values |
| sync_mode | input | 2 | 00/01 off, 10 master, 11 slave |
| blink_en | input | NCH | Per-channel blink enable |
| sync_in | input | 1 | Sync pin input |
| blink_gate | output | 1 | Shared blink gate |
| ch_gate | output | NCH | Per-channel PWM release |
| sync_out | output | 1 | Sync pin output value |
| sync_oe | output | 1 | Sync pin output enable |

## Verification
A wrong slot counter or prescaler shows up at the ports as a wrong count of gate-high cycles within a single blink period, or as a wrong spacing between gate rising edges. Either one is visible within one period of 256*(BLF+1) ticks. A slave that restarts at the wrong time shows up within three clocks of the sync edge: the gate does not rise on the expected cycle. It shows up again 64 slots later, when the gate does not close on the expected cycle. Committed values that leak early show up as a wrong on-count in the very next period.

// File: rtl/blink_gen.sv
module blink_gen #(
  parameter int NCH = 18,
  parameter int VW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [VW-1:0]  blf_next,
  input  logic [VW-1:0]  bld_next,
  input  logic           update,
  input  logic [1:0]     sync_mode,
  input  logic [NCH-1:0] blink_en,
  input  logic           sync_in,
  output logic           blink_gate,
  output logic [NCH-1:0] ch_gate,
  output logic           sync_out,
  output logic           sync_oe
);
  localparam logic [1:0] MODE_MASTER = 2'b10;
  localparam logic [1:0] MODE_SLAVE  = 2'b11;

  logic [VW-1:0] blf_act, bld_act, pre, slot;
  logic [2:0]    sync_q;
  logic          restart;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      blf_act <= '0;
      bld_act <= '0;
    end else if (update) begin
      blf_act <= blf_next;
      bld_act <= bld_next;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], sync_in};

  assign restart = (sync_mode == MODE_SLAVE) && sync_q[1] && !sync_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre  <= '0;
      slot <= '0;
    end else if (restart) begin
      pre  <= '0;
      slot <= '0;
    end else if (tick) begin
      if (pre >= blf_act) begin
        pre  <= '0;
        slot <= slot + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end

  assign blink_gate = slot < bld_act;
  assign ch_gate    = ~blink_en | {NCH{blink_gate}};
  assign sync_out   = (sync_mode == MODE_MASTER) && !slot[VW-1];
  assign sync_oe    = sync_mode != MODE_SLAVE;
endmodule

// File: rtl/blink_gen_chk.sv
module blink_gen_chk #(
  parameter int NCH = 18,
  parameter int VW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           update,
  input logic [1:0]     sync_mode,
  input logic [NCH-1:0] blink_en,
  input logic           blink_gate,
  input logic [NCH-1:0] ch_gate,
  input logic           sync_out,
  input logic           sync_oe,
  input logic           restart,
  input logic [VW-1:0]  slot,
  input logic [VW-1:0]  bld_act,
  input logic [VW-1:0]  blf_act
);
  assert_zero_duty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bld_act == '0 |-> !blink_gate);
  assert_hold_until_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(bld_act) && $stable(blf_act));
  assert_channel_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_gate & ~blink_en) == ~blink_en) &&
    ((ch_gate & blink_en) == ({NCH{blink_gate}} & blink_en)));
  assert_pin_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode[1] |-> sync_oe && !sync_out);
  assert_master_drives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode == 2'b10 |-> sync_oe);
  assert_slave_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode == 2'b11 |-> !sync_oe);
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> slot == '0);
  assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !restart |=> $stable(slot));
endmodule

bind blink_gen blink_gen_chk #(.NCH(NCH), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .update(update),
  .sync_mode(sync_mode), .blink_en(blink_en), .blink_gate(blink_gate),
  .ch_gate(ch_gate), .sync_out(sync_out), .sync_oe(sync_oe),
  .restart(restart), .slot(slot), .bld_act(bld_act), .blf_act(blf_act)
);

// File: tb/blink_gen_test.sv
module blink_gen_test;
  localparam int NCH = 18;
  logic clk = 0, rst_n = 0, tick = 0, update = 0, sync_in = 0;
  logic [7:0] blf_next = 0, bld_next = 0;
  logic [1:0] sync_mode = 0;
  logic [NCH-1:0] blink_en = 0;
  logic blink_gate, sync_out, sync_oe;
  logic [NCH-1:0] ch_gate;
  int tick_sel = 0;
  int n_chk = 0, n_bad = 0, cyc = 0;

  blink_gen #(.NCH(NCH), .VW(8)) uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    tick <= (tick_sel == 0) ? 1'b1 : (tick_sel == 1) ? ~tick : 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic commit(input int f, input int d);
    @(negedge clk); blf_next = 8'(f); bld_next = 8'(d); update = 1;
    @(negedge clk); update = 0;
  endtask

  task automatic count_high(input int n, output int hi, output int so);
    hi = 0; so = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(blink_gate);
      so += int'(sync_out);
    end
  endtask

  task automatic gate_period(output int p);
    int k = 0;
    p = 0;
    while (blink_gate && k < 5000) begin @(negedge clk); k++; end
    while (!blink_gate && k < 5000) begin @(negedge clk); k++; end
    @(negedge clk); p = 1;
    while (blink_gate && p < 5000) begin @(negedge clk); p++; end
    while (!blink_gate && p < 5000) begin @(negedge clk); p++; end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(blink_gate == 0, "R9 gate after reset", blink_gate, 0);
    chk(sync_oe == 1 && sync_out == 0, "R5 pin after reset", {sync_oe, sync_out}, 2);
  endtask

  task automatic t_duty;
    int hi, so, p;
    commit(0, 64);  count_high(256, hi, so); chk(hi == 64,  "R2 duty 64", hi, 64);
    commit(0, 255); count_high(256, hi, so); chk(hi == 255, "R2 duty 255", hi, 255);
    commit(0, 0);   count_high(512, hi, so); chk(hi == 0,   "R2 duty 0", hi, 0);
    commit(2, 100); gate_period(p);          chk(p == 768,  "R1 period blf=2", p, 768);
    count_high(768, hi, so); chk(hi == 300, "R2 duty over blf=2", hi, 300);
  endtask

  task automatic t_update;
    int hi, so;
    commit(0, 64);
    @(negedge clk); bld_next = 200; blf_next = 5;
    count_high(256, hi, so); chk(hi == 64, "R3 staged value ignored", hi, 64);
    @(negedge clk); update = 1; @(negedge clk); update = 0;
    count_high(256 * 6, hi, so); chk(hi == 200 * 6, "R3 committed value used", hi, 1200);
  endtask

  task automatic t_tick;
    int hi, so;
    commit(0, 64);
    tick_sel = 1; repeat (2) @(negedge clk);
    count_high(512, hi, so); chk(hi == 128, "R8 half-rate tick", hi, 128);
    tick_sel = 2; repeat (2) @(negedge clk);
    count_high(300, hi, so); chk(hi == 0 || hi == 300, "R8 no tick, gate frozen", hi, 0);
    tick_sel = 0;
  endtask

  task automatic t_channels;
    int bad = 0;
    commit(0, 128);
    blink_en = 18'h2A5C3;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ch_gate !== (~blink_en | {NCH{blink_gate}})) bad++;
    end
    chk(bad == 0, "R4 per-channel release", bad, 0);
    blink_en = '0;
    @(negedge clk);
    chk(ch_gate == '1, "R4 all disabled pass", int'(ch_gate), (1 << NCH) - 1);
  endtask

  task automatic t_off_modes;
    int bad = 0;
    commit(0, 64);
    sync_mode = 2'b01;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!sync_oe || sync_out) bad++;
    end
    chk(bad == 0, "R5 mode 01 pin low", bad, 0);
    sync_mode = 2'b00;
  endtask

  task automatic t_master;
    int hi, so, k = 0, p = 0;
    commit(1, 64);
    sync_mode = 2'b10;
    @(negedge clk);
    chk(sync_oe == 1, "R6 master oe", sync_oe, 1);
    count_high(512, hi, so); chk(so == 256, "R6 square wave half", so, 256);
    while (sync_out && k < 3000) begin @(negedge clk); k++; end
    while (!sync_out && k < 3000) begin @(negedge clk); k++; end
    @(negedge clk); p = 1;
    while (sync_out && p < 3000) begin @(negedge clk); p++; end
    while (!sync_out && p < 3000) begin @(negedge clk); p++; end
    chk(p == 512, "R6 master period blf=1", p, 512);
    chk(blink_gate == 1, "R6 gate opens with sync rise", blink_gate, 1);
    sync_mode = 2'b00;
  endtask

  task automatic t_slave;
    int hi, so, k = 0;
    commit(0, 64);
    sync_mode = 2'b11; sync_in = 0;
    @(negedge clk);
    chk(sync_oe == 0, "R7 slave oe", sync_oe, 0);
    while (blink_gate && k < 1000) begin @(negedge clk); k++; end
    sync_in = 1;
    repeat (3) @(negedge clk);
    chk(blink_gate == 1, "R7 restart opens gate", blink_gate, 1);
    repeat (63) @(negedge clk);
    chk(blink_gate == 1, "R7 slot 63 still open", blink_gate, 1);
    @(negedge clk);
    chk(blink_gate == 0, "R7 slot 64 closed", blink_gate, 0);
    sync_in = 0;
    repeat (30) @(negedge clk);
    for (int w = 0; w < 3; w++) begin
      sync_in = 1; count_high(10, hi, so);
      begin
        int h2, s2;
        sync_in = 0; count_high(90, h2, s2);
        chk(hi + h2 == 64, "R7 locked 100-cycle window", hi + h2, 64);
      end
    end
    sync_mode = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_duty();
    t_update();
    t_tick();
    t_channels();
    t_off_modes();
    t_master();
    t_slave();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule